// File: doc/BRIEF.md
# ECG R-Peak Detector

This block watches a stream of signed electrocardiogram samples, arriving at 200 samples per second (5 ms apart), and marks the samples that hold an R peak. The samples pass through four stages in a fixed order. The first stage takes the difference between each sample and the previous one. The second stage rectifies that difference with an absolute value, not a square, so downward swings count as much as upward ones. The third stage smooths the rectified values with a 30-sample moving sum. The last stage checks each smoothed value against the eight smoothed values that follow it and against a threshold supplied by the caller.

When a smoothed value beats all eight of its successors and is above the threshold, the block raises a one-cycle strobe. At the same time it presents the sample index of the peak, counted from zero after reset. To turn an index into a time, multiply it by 5 ms. After each reported peak, a 40-sample refractory window stops one QRS complex from being reported twice. All arithmetic uses fixed-point integers.

Top module: `ecg_rpeak_detect`

## Requirements
- R1: While reset is held low, and in the first cycle after reset is released, `peak_strobe` is 0 and `peak_index` is 0.
- R2: The difference stage computes x[n] - x[n-1]. The first sample accepted after reset always gives a difference of 0, so a constant input of any level never produces a peak.
- R3: The rectified value is the absolute value of the difference. A falling edge or a negative impulse therefore produces the same peak, at the same index, as a rising edge or positive impulse of equal size.
- R4: The smoothed value for sample n is the sum of the rectified values of samples n-29 through n. A step of height A at sample s, with threshold below A, gives exactly one peak, at index s+29.
- R5: The 24-bit smoothed sum never wraps. A run of alternating full-scale samples (+32767 and -32768) reaches 30 x 65535 and is reported as a peak at the last sample of the run.
- R6: Smoothed sample c is a candidate only if it is strictly greater than each of smoothed samples c+1 through c+8. If any of them is equal to c, the candidate is rejected.
- R7: A candidate is reported only if its smoothed value is strictly greater than `thresh`. A value equal to `thresh` is not reported, and `thresh` can be changed between signal segments.
- R8: After a peak at index p, every candidate with an index below p+40 is rejected. A candidate at index p+40 can be reported.
- R9: A peak at index c is reported by `peak_strobe`, high for one cycle, starting at the second rising clock edge after the edge that accepts input sample c+8. `peak_index` equals c in that cycle and keeps its value until the next peak is reported.
- R10: A sample is taken only on a clock edge where `smp_valid` is 1. Values on `smp_data` while `smp_valid` is 0 have no effect on the reported peaks or indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Qualifies `smp_data` on this edge |
| smp_data | input | 16 | Signed two's-complement ECG sample |
| thresh | input | 24 | Unsigned amplitude threshold for the smoothed signal |
| peak_strobe | output | 1 | One-cycle pulse when an R peak is reported |
| peak_index | output | 32 | Sample index of the latest reported peak |

## Verification
Any corruption inside this block reaches the ports in a predictable way. A bad stored previous sample, or a stale entry in the window history, changes the smoothed values, and the effect shows up as a moved or missing strobe between 8 and 38 samples later. A bad look-ahead entry or fill count changes a peak decision within the next eight samples. A refractory counter that is too short or too long shows up as a second peak inside the 40-sample window, or as a lost peak just after it. Each expected index and strobe cycle is worked out from the requirements for steps, impulses, ties, threshold boundaries, full-scale input and a noisy beat pattern with random gaps in `smp_valid`.

// File: rtl/rpk_pkg.sv
// Shared defaults and helpers for the R-peak detector.
// Assumes: sample width below 32 bits, window length at least 2.
package rpk_pkg;
    localparam int unsigned DEF_SMP_W = 16;  // input sample width
    localparam int unsigned DEF_ACC_W = 24;  // smoothing accumulator width
    localparam int unsigned DEF_WIN   = 30;  // integration window, samples
    localparam int unsigned DEF_LOOK  = 8;   // look-ahead depth, samples
    localparam int unsigned DEF_REFR  = 40;  // refractory length, samples
    localparam int unsigned DEF_IDX_W = 32;  // sample index width

    // Largest sum the window can hold: win entries of the largest magnitude.
    function automatic longint unsigned sum_ceiling(int unsigned win, int unsigned smp_w);
        return 64'(win) * ((64'(1) << smp_w) - 64'(1));
    endfunction
endpackage

// File: rtl/rpk_diff_rect.sv
// First difference followed by absolute value, one register stage.
// Assumes: samples are signed; the first sample after reset has no
// predecessor and is treated as a zero difference.
module rpk_diff_rect #(
    parameter int unsigned SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_data,
    output logic                    out_valid,
    output logic [SMP_W:0]          out_mag
);
    logic signed [SMP_W-1:0] prev_q;
    logic                    primed_q;
    logic signed [SMP_W:0]   delta;
    logic [SMP_W:0]          mag_d;

    // Difference with one extra bit, then magnitude.
    always_comb begin
        if (primed_q) begin
            delta = $signed({in_data[SMP_W-1], in_data}) - $signed({prev_q[SMP_W-1], prev_q});
        end else begin
            delta = '0;
        end
        mag_d = delta[SMP_W] ? $unsigned(-delta) : $unsigned(delta);
    end

    // Keep the last sample and register the magnitude.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            primed_q  <= 1'b0;
            out_valid <= 1'b0;
            out_mag   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prev_q   <= in_data;
                primed_q <= 1'b1;
                out_mag  <= mag_d;
            end
        end
    end

    // R2: every accepted sample yields one output one edge later.
    a_r2_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2: first sample after reset gives a zero magnitude.
    a_r2_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !primed_q) |=> (out_mag == '0));
endmodule

// File: rtl/rpk_window_sum.sv
// Moving-window integrator: running sum of the last WIN magnitudes.
// A circular history supplies the value that leaves the window.
// Assumes: ACC_W is wide enough for WIN full-scale magnitudes.
module rpk_window_sum
    import rpk_pkg::*;
#(
    parameter int unsigned IN_W  = 17,
    parameter int unsigned ACC_W = 24,
    parameter int unsigned WIN   = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_mag,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_sum
);
    localparam int unsigned     PTR_W   = $clog2(WIN);
    localparam longint unsigned SUM_MAX = sum_ceiling(WIN, IN_W - 1);

    logic [IN_W-1:0]  hist_q [WIN];
    logic [PTR_W-1:0] ptr_q;
    logic [ACC_W-1:0] sum_q;
    logic [ACC_W-1:0] sum_d;

    // Add the newest magnitude, drop the oldest.
    always_comb begin
        sum_d = sum_q + ACC_W'(in_mag) - ACC_W'(hist_q[ptr_q]);
    end

    // History write, pointer advance and sum update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WIN; k++) begin
                hist_q[k] <= '0;
            end
            ptr_q     <= '0;
            sum_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hist_q[ptr_q] <= in_mag;
                ptr_q         <= (ptr_q == PTR_W'(WIN - 1)) ? '0 : ptr_q + PTR_W'(1);
                sum_q         <= sum_d;
            end
        end
    end

    assign out_sum = sum_q;

    // R5: the sum never exceeds the full-scale ceiling.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        64'(out_sum) <= SUM_MAX);
    // R5: when the entering value is not smaller than the leaving one, the sum cannot fall (a wrap would).
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mag >= hist_q[ptr_q])) |=> (out_sum >= $past(out_sum)));
    // R4: each magnitude produces one smoothed value one edge later.
    a_r4_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

// File: rtl/rpk_peak_pick.sv
// Look-ahead peak picker with threshold and refractory hold.
// Holds the last LOOK smoothed values; the oldest one is the candidate,
// judged when the next value arrives. Assumes LOOK >= 2, REFR >= 2.
module rpk_peak_pick #(
    parameter int unsigned VAL_W = 24,
    parameter int unsigned LOOK  = 8,
    parameter int unsigned REFR  = 40,
    parameter int unsigned IDX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VAL_W-1:0] in_val,
    input  logic [VAL_W-1:0] thresh,
    output logic             peak_strobe,
    output logic [IDX_W-1:0] peak_index
);
    localparam int unsigned FILL_W = $clog2(LOOK + 1);
    localparam int unsigned RC_W   = $clog2(REFR);

    logic [VAL_W-1:0]  la_q [LOOK];
    logic [FILL_W-1:0] fill_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RC_W-1:0]   hold_q;
    logic [LOOK-1:0]   beats;
    logic [VAL_W-1:0]  cand;
    logic              full;
    logic              fire;

    assign cand = la_q[LOOK-1];
    assign full = (fill_q == FILL_W'(LOOK));

    // One strict comparator per later sample; ties fail.
    for (genvar k = 0; k < LOOK - 1; k++) begin : g_cmp
        assign beats[k] = cand > la_q[k];
    end
    assign beats[LOOK-1] = cand > in_val;

    // Peak decision for the candidate as its last successor arrives.
    always_comb begin
        fire = in_valid && full && (&beats) && (cand > thresh) && (hold_q == '0);
    end

    // Shift the look-ahead window on each smoothed value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LOOK; k++) begin
                la_q[k] <= '0;
            end
        end else if (in_valid) begin
            la_q[0] <= in_val;
            for (int k = 1; k < LOOK; k++) begin
                la_q[k] <= la_q[k-1];
            end
        end
    end

    // Fill count, sample index, refractory counter and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q      <= '0;
            idx_q       <= '0;
            hold_q      <= '0;
            peak_strobe <= 1'b0;
            peak_index  <= '0;
        end else begin
            peak_strobe <= fire;
            if (in_valid) begin
                idx_q <= idx_q + IDX_W'(1);
                if (!full) begin
                    fill_q <= fill_q + FILL_W'(1);
                end
                if (fire) begin
                    peak_index <= idx_q - IDX_W'(LOOK);
                    hold_q     <= RC_W'(REFR - 1);
                end else if (full && (hold_q != '0)) begin
                    hold_q <= hold_q - RC_W'(1);
                end
            end
        end
    end

    // R8: the refractory hold rules out strobes on consecutive cycles.
    a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        peak_strobe |=> !peak_strobe);
    // R9: a strobe only follows an edge that took a smoothed value.
    a_r9_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        peak_strobe |-> $past(in_valid));
    // R9: the index holds between strobes.
    a_r9_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_strobe |-> $stable(peak_index));
endmodule

// File: rtl/ecg_rpeak_detect.sv
// R-peak detector top: difference, magnitude, moving sum, look-ahead pick.
// Assumes: samples arrive at a fixed rate at most one per clock;
// thresh is held steady while samples flow.
module ecg_rpeak_detect
    import rpk_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned ACC_W = DEF_ACC_W,
    parameter int unsigned WIN   = DEF_WIN,
    parameter int unsigned LOOK  = DEF_LOOK,
    parameter int unsigned REFR  = DEF_REFR,
    parameter int unsigned IDX_W = DEF_IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic [ACC_W-1:0]        thresh,
    output logic                    peak_strobe,
    output logic [IDX_W-1:0]        peak_index
);
    localparam int unsigned MAG_W = SMP_W + 1;

    logic             mag_valid;
    logic [MAG_W-1:0] mag;
    logic             sum_valid;
    logic [ACC_W-1:0] sum;

    rpk_diff_rect #(.SMP_W(SMP_W)) u_diff (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_data   (smp_data),
        .out_valid (mag_valid),
        .out_mag   (mag)
    );

    rpk_window_sum #(.IN_W(MAG_W), .ACC_W(ACC_W), .WIN(WIN)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mag_valid),
        .in_mag    (mag),
        .out_valid (sum_valid),
        .out_sum   (sum)
    );

    rpk_peak_pick #(.VAL_W(ACC_W), .LOOK(LOOK), .REFR(REFR), .IDX_W(IDX_W)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (sum_valid),
        .in_val      (sum),
        .thresh      (thresh),
        .peak_strobe (peak_strobe),
        .peak_index  (peak_index)
    );
endmodule

// File: tb/ecg_rpeak_detect_tb.sv
`timescale 1ns/1ps
module ecg_rpeak_detect_tb;
    localparam int MAXS = 4096;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic [23:0]        thresh = 24'd8000;
    logic               peak_strobe;
    logic [31:0]        peak_index;

    ecg_rpeak_detect u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thresh(thresh), .peak_strobe(peak_strobe), .peak_index(peak_index)
    );

    always #2 clk = ~clk;  // 250 MHz

    int checks = 0, fails = 0, edge_cnt = 0, n_sent = 0;
    int seg_exp = 0, seg_got = 0, last_got = -1;
    int acc_edge [MAXS];
    int integ [MAXS];
    int ring [30];
    int q_exp [$];
    int m_prev = 0, m_sum = 0, m_last = -1000, th = 8000;
    bit m_first = 1'b1, done = 1'b0;
    int unsigned lf = 32'h1234_5678;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    function automatic int unsigned rnd();
        lf = lf * 32'd1103515245 + 32'd12345;
        return lf >> 8;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements; pushes expected peaks.
    task automatic model(input int x);
        int d, r, c;
        bit ok;
        d = m_first ? 0 : x - m_prev;
        m_first = 1'b0;
        m_prev = x;
        r = (d < 0) ? -d : d;
        m_sum = m_sum + r - ring[n_sent % 30];
        ring[n_sent % 30] = r;
        integ[n_sent] = m_sum;
        if (n_sent >= 8) begin
            c = n_sent - 8;
            ok = integ[c] > th;
            for (int k = 1; k <= 8; k++) if (integ[c+k] >= integ[c]) ok = 1'b0;
            if (ok && c >= m_last + 40) begin
                q_exp.push_back(c);
                m_last = c;
                seg_exp++;
            end
        end
    endtask

    // Driver: present one sample at a falling edge, then optional idle gap with junk data.
    task automatic send(input int x, input int gap);
        model(x);
        smp_valid = 1'b1;
        smp_data = 16'(x);
        acc_edge[n_sent] = edge_cnt + 1;
        n_sent++;
        @(negedge clk);
        if (gap > 0) begin
            smp_valid = 1'b0;
            repeat (gap) begin
                smp_data = 16'(rnd());
                @(negedge clk);
            end
        end
    endtask

    task automatic hold(input int x, input int n, input int gap);
        repeat (n) send(x, gap);
    endtask

    task automatic idle(input int n);
        smp_valid = 1'b0;
        repeat (n) begin
            smp_data = 16'(rnd());
            @(negedge clk);
        end
    endtask

    task automatic end_seg(input string tag, input int hand);
        idle(6);
        chk(seg_got == seg_exp, {tag, " peak count vs scoreboard"}, seg_got, seg_exp);
        if (hand >= 0) chk(seg_got == hand, {tag, " peak count"}, seg_got, hand);
        chk(q_exp.size() == 0, {tag, " pending expected peaks"}, q_exp.size(), 0);
        seg_got = 0;
        seg_exp = 0;
    endtask

    // Monitor: pop expected peak, compare index and strobe timing.
    always @(negedge clk) begin
        if (rst_n && peak_strobe) begin
            int e;
            seg_got++;
            last_got = int'(peak_index);
            if (q_exp.size() == 0) begin
                chk(1'b0, "R6 unexpected peak index", int'(peak_index), -1);
            end else begin
                e = q_exp.pop_front();
                chk(int'(peak_index) == e, "R6 peak index", int'(peak_index), e);
                chk(edge_cnt == acc_edge[e+8] + 2, "R9 strobe edge", edge_cnt, acc_edge[e+8] + 2);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int s, s2, i, nl;
        for (int k = 0; k < 30; k++) ring[k] = 0;
        repeat (4) @(negedge clk);
        chk(peak_strobe == 1'b0, "R1 strobe in reset", peak_strobe, 0);
        chk(peak_index == 32'd0, "R1 index in reset", int'(peak_index), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(peak_strobe == 1'b0 && peak_index == 32'd0, "R1 after release", int'(peak_index), 0);

        // R2: high first level, never a peak.
        hold(9000, 50, 1);
        end_seg("R2", 0);

        // R3 / R4: falling step of 9000.
        s = n_sent;
        hold(0, 50, 2);
        end_seg("R3", 1);
        chk(last_got == s + 29, "R4 step peak index", last_got, s + 29);

        // R7: height equal to threshold, both directions.
        hold(8000, 50, 0);
        hold(0, 50, 1);
        end_seg("R7 equal", 0);

        // R7: one above threshold.
        s = n_sent;
        hold(8001, 50, 1);
        end_seg("R7 above", 1);
        chk(last_got == s + 29, "R7 above index", last_got, s + 29);
        s2 = n_sent;
        hold(0, 50, 0);
        end_seg("R3 fall", 1);
        chk(last_got == s2 + 29, "R3 fall index", last_got, s2 + 29);

        // R3: negative impulse.
        s = n_sent;
        send(-6000, 1);
        hold(0, 50, 1);
        end_seg("R3 impulse", 1);
        chk(last_got == s + 29, "R3 impulse index", last_got, s + 29);

        // R8: second peak 39 samples later is suppressed.
        i = n_sent;
        send(6000, 1); hold(0, 38, 1); send(5000, 1); hold(0, 60, 1);
        end_seg("R8 gap39", 1);
        chk(last_got == i + 29, "R8 gap39 index", last_got, i + 29);

        // R8: exactly 40 samples apart is allowed.
        i = n_sent;
        send(6000, 0); hold(0, 39, 0); send(5000, 0); hold(0, 60, 0);
        end_seg("R8 gap40", 2);
        chk(last_got == i + 69, "R8 gap40 index", last_got, i + 69);

        // R6: an equal later value disqualifies the first candidate.
        i = n_sent;
        send(6000, 1); hold(0, 35, 1); send(6000, 1); hold(0, 60, 1);
        end_seg("R6 tie", 1);
        chk(last_got == i + 65, "R6 tie index", last_got, i + 65);

        // R7: raised threshold blocks a 15000 step.
        idle(4);
        th = 20000;
        thresh = 24'd20000;
        idle(2);
        hold(15000, 50, 1);
        hold(0, 50, 1);
        end_seg("R7 programmed", 0);
        idle(4);
        th = 8000;
        thresh = 24'd8000;
        idle(2);

        // R5: full-scale alternation, back to back.
        for (int k = 0; k < 40; k++) send((k % 2 == 0) ? 32767 : -32768, 0);
        nl = n_sent - 1;
        hold(-32768, 49, 0);
        end_seg("R5 full scale", 1);
        chk(last_got == nl, "R5 full scale index", last_got, nl);
        hold(0, 50, 0);
        end_seg("R5 return", 1);

        // R10: noisy beats with random gaps and junk data between samples.
        for (int b = 0; b < 8; b++) begin
            for (int o = 0; o < 75; o++) begin
                int v;
                v = int'(rnd() % 301) - 150;
                if (o == 10) v += 2000;
                if (o == 11) v += 9000;
                if (o == 12) v -= 3000;
                if (o == 13) v += 500;
                send(v, int'(rnd() % 4));
            end
        end
        hold(0, 50, 1);
        end_seg("R10 beats", -1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule